// File: doc/BRIEF.md
# Runtime-Partitioned SIMD Minimum Unit

This block returns the smaller of two operands, where the operand width is split at runtime into independent segments. The datapath is a row of narrow base lanes. A control mask holds one bit per inner lane boundary. A bit set to one cuts the datapath at that boundary. A bit set to zero fuses the lanes on both sides into one wider segment. One comparator serves a single full-width compare, several narrow lane compares, and any uneven mix of the two. There is no separate scalar unit and no separate vector unit.

Each lane makes a "less" flag and an "equal" flag. These flags are chained from the low lane upward across fused boundaries, and the chain restarts at every cut. The decision formed at the top lane of a segment is then passed back down to every lane of that segment. Every lane of a segment therefore copies the same operand. The unit is purely combinational: the output follows both operands and the mask within the same cycle, and the mask may differ on every cycle.

Top module: `simd_min_unit`

## Requirements
- R1: With the defaults, the 16-bit operands split into four 4-bit lanes. Lane k occupies bits 4k+3..4k. Mask bit k sits on the boundary between lane k and lane k+1.
- R2: A mask bit of 0 fuses its two neighbouring lanes into one segment. A mask bit of 1 keeps them in separate segments.
- R3: With mask 3'b000, the output is the 16-bit unsigned minimum of the two operands.
- R4: With mask 3'b111, each 4-bit output lane is the unsigned minimum of the matching operand lanes, independent of the other lanes.
- R5: Every one of the 8 mask values is legal. For each mask, every output segment equals the unsigned minimum of the matching operand segments. This includes uneven mixes such as one 8-bit segment beside two 4-bit segments.
- R6: The compare is unsigned. Inside a fused segment, the most significant lane whose operand digits differ decides the result.
- R7: When the two operand segments are equal, the output segment equals that common value. In this case the y operand is the one selected.
- R8: Every output lane is a copy of the x lane or of the y lane. All lanes of one segment copy the same operand.
- R9: The output is combinational. A change of only the mask, with the operands held, changes the output with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_x | input | 16 | First operand; copied to a segment when it is strictly smaller |
| op_y | input | 16 | Second operand; copied to a segment when the first is not smaller |
| part_mask | input | 3 | Boundary control; bit k cuts (1) or fuses (0) lanes k and k+1 |
| min_out | output | 16 | Per-segment unsigned minimum |

## Verification
The bench builds the unit with its default shape: four lanes of four bits. With this shape all 8 partition masks can be swept exhaustively, and each segment is small enough that operands can be chosen to hit a chosen lane. The bench uses borrow-like patterns such as 0x8001 against 0x7FFF and 0xFFF0 against 0xFFEF. These patterns show whether a fused segment's decision really comes from its top differing lane, and whether a cut boundary really isolates its lanes. The bench also sweeps pseudo-random and saturated operands under every mask and compares the result with a model that slices the operands by segment.

// File: rtl/simd_min_pkg.sv
// Package: shared types for the partitioned minimum unit.
// Assumes: one flag pair per base lane is all that crosses a lane boundary.
package simd_min_pkg;

    // Per-lane comparison outcome of operand x against operand y
    typedef struct packed {
        logic lt;   // x lane strictly below y lane
        logic eq;   // x lane equal to y lane
    } lane_flags_t;

endpackage

// File: rtl/simd_lane_cmp.sv
// Module: simd_lane_cmp
// Compares one base lane of x against y without sign and reports less/equal.
// Assumes: lanes are unsigned digits of a wider number; no carry enters here.
module simd_lane_cmp
    import simd_min_pkg::*;
#(
    parameter int LANE_W = 4
) (
    input  logic [LANE_W-1:0] lane_x,
    input  logic [LANE_W-1:0] lane_y,
    output lane_flags_t       flags
);

    // Form the less and equal flags of this lane
    always_comb begin
        flags.lt = (lane_x < lane_y);
        flags.eq = (lane_x == lane_y);
    end

    // A lane can never be both below and equal (R6)
    always_comb begin
        assert_flags_exclusive_R6: assert (!(flags.lt && flags.eq))
            else $error("lane flags both set");
    end

endmodule

// File: rtl/simd_cmp_cascade.sv
// Module: simd_cmp_cascade
// Chains the lane flags upward across fused boundaries, then hands each
// segment's top-lane decision back down to every lane of that segment.
// Assumes: cut[k]=1 separates lane k from lane k+1; LANES >= 2.
module simd_cmp_cascade
    import simd_min_pkg::*;
#(
    parameter int LANES = 4,
    localparam int CUTS = LANES - 1
) (
    input  lane_flags_t [LANES-1:0] flags,
    input  logic [CUTS-1:0]         cut,
    output logic [LANES-1:0]        take_x
);

    logic [LANES-1:0] chain_lt;

    // Upward chain: a lane decides if it differs, else defers to the lane below
    always_comb begin
        chain_lt[0] = flags[0].lt;
        for (int i = 1; i < LANES; i++) begin
            chain_lt[i] = flags[i].lt |
                          (flags[i].eq & ~cut[i-1] & chain_lt[i-1]);
        end
    end

    // Downward broadcast: the top lane of each segment sets the segment select
    always_comb begin
        take_x[LANES-1] = chain_lt[LANES-1];
        for (int i = LANES - 2; i >= 0; i--) begin
            take_x[i] = cut[i] ? chain_lt[i] : take_x[i+1];
        end
    end

    // Fused neighbours always agree on the operand (R2, R8)
    always_comb begin
        for (int k = 0; k < CUTS; k++) begin
            if (!cut[k]) begin
                assert_fused_agree_R2: assert (take_x[k] == take_x[k+1])
                    else $error("fused lanes %0d/%0d disagree", k, k + 1);
            end
        end
    end

    // With every boundary cut, each lane follows only its own flag (R4)
    always_comb begin
        if (&cut) begin
            for (int i = 0; i < LANES; i++) begin
                assert_isolated_lane_R4: assert (take_x[i] == flags[i].lt)
                    else $error("isolated lane %0d leaks", i);
            end
        end
    end

endmodule

// File: rtl/simd_lane_select.sv
// Module: simd_lane_select
// Routes, lane by lane, either the x digit or the y digit to the output.
// Assumes: take_x is already uniform across each segment.
module simd_lane_select #(
    parameter int LANE_W = 4,
    parameter int LANES  = 4,
    localparam int DATA_W = LANE_W * LANES
) (
    input  logic [DATA_W-1:0] sel_x,
    input  logic [DATA_W-1:0] sel_y,
    input  logic [LANES-1:0]  take_x,
    output logic [DATA_W-1:0] sel_out
);

    // Per-lane two-way multiplexer
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign sel_out[g*LANE_W +: LANE_W] = take_x[g] ? sel_x[g*LANE_W +: LANE_W]
                                                       : sel_y[g*LANE_W +: LANE_W];
    end

    // Every output lane is a copy of one operand lane (R8)
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            assert_lane_is_copy_R8: assert (
                (sel_out[i*LANE_W +: LANE_W] == sel_x[i*LANE_W +: LANE_W]) ||
                (sel_out[i*LANE_W +: LANE_W] == sel_y[i*LANE_W +: LANE_W]))
                else $error("lane %0d is neither operand", i);
        end
    end

endmodule

// File: rtl/simd_min_unit.sv
// Module: simd_min_unit (top)
// Per-segment unsigned minimum of two operands, with segment boundaries
// chosen at runtime by part_mask. Purely combinational: no clock, no reset.
// Assumes: LANES >= 2; mask bit k lies between lane k and lane k+1.
module simd_min_unit
    import simd_min_pkg::*;
#(
    parameter int LANE_W = 4,
    parameter int LANES  = 4,
    localparam int DATA_W = LANE_W * LANES,
    localparam int CUTS   = LANES - 1
) (
    input  logic [DATA_W-1:0] op_x,
    input  logic [DATA_W-1:0] op_y,
    input  logic [CUTS-1:0]   part_mask,
    output logic [DATA_W-1:0] min_out
);

    lane_flags_t [LANES-1:0] lane_flags;
    logic [LANES-1:0]        lane_take_x;

    // One comparator slice per base lane (R1)
    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        simd_lane_cmp #(.LANE_W(LANE_W)) u_cmp (
            .lane_x (op_x[g*LANE_W +: LANE_W]),
            .lane_y (op_y[g*LANE_W +: LANE_W]),
            .flags  (lane_flags[g])
        );
    end

    simd_cmp_cascade #(.LANES(LANES)) u_cascade (
        .flags  (lane_flags),
        .cut    (part_mask),
        .take_x (lane_take_x)
    );

    simd_lane_select #(.LANE_W(LANE_W), .LANES(LANES)) u_select (
        .sel_x   (op_x),
        .sel_y   (op_y),
        .take_x  (lane_take_x),
        .sel_out (min_out)
    );

    // Fully fused datapath behaves as one wide comparator (R3)
    always_comb begin
        if (part_mask == '0) begin
            assert_full_width_R3: assert (min_out == ((op_x < op_y) ? op_x : op_y))
                else $error("full-width minimum wrong");
        end
    end

    // Equal operands yield the common value (R7)
    always_comb begin
        if (op_x == op_y) begin
            assert_equal_passes_R7: assert (min_out == op_y)
                else $error("equal operands altered");
        end
    end

endmodule

// File: tb/simd_min_unit_test.sv
// Self-checking bench for simd_min_unit: a vector table, then sweeps and corners.
module simd_min_unit_test;

    localparam int LANE_W = 4;
    localparam int LANES  = 4;
    localparam int DATA_W = LANE_W * LANES;
    localparam int CUTS   = LANES - 1;
    localparam int NVEC   = 12;

    logic clk = 1'b0;
    logic [DATA_W-1:0] op_x, op_y, min_out;
    logic [CUTS-1:0]   part_mask;
    int checks = 0;
    int fails  = 0;
    logic [15:0] lfsr = 16'hACE1;

    // 50 MHz clock paces the stimulus
    always #10 clk = ~clk;

    simd_min_unit uut (
        .op_x      (op_x),
        .op_y      (op_y),
        .part_mask (part_mask),
        .min_out   (min_out)
    );

    // {mask, x, y, expected}: hand-computed per requirement
    localparam logic [50:0] VEC [0:NVEC-1] = '{
        {3'b000, 16'h1234, 16'h1243, 16'h1234},  // R3
        {3'b111, 16'h1234, 16'h4321, 16'h1221},  // R4
        {3'b000, 16'h0F00, 16'h00FF, 16'h00FF},  // R3, R6
        {3'b111, 16'h0F00, 16'h00FF, 16'h0000},  // R4
        {3'b101, 16'hA5C3, 16'h5A3C, 16'h55C3},  // R5 uneven
        {3'b010, 16'h8001, 16'h7FFF, 16'h7F01},  // R2 halves
        {3'b000, 16'h8001, 16'h7FFF, 16'h7FFF},  // R6 top lane decides
        {3'b001, 16'hFFF0, 16'hFFEF, 16'hFFE0},  // R5
        {3'b100, 16'h1FFF, 16'h2000, 16'h1000},  // R5
        {3'b011, 16'h3412, 16'h3421, 16'h3411},  // R7 equal upper segment
        {3'b110, 16'h9876, 16'h8967, 16'h8867},  // R1 lane placement
        {3'b111, 16'hFFFF, 16'hFFFF, 16'hFFFF}   // R7
    };

    // Reference: slice by mask, compare each segment as a whole number
    function automatic logic [DATA_W-1:0] ref_min(input logic [DATA_W-1:0] x,
                                                  input logic [DATA_W-1:0] y,
                                                  input logic [CUTS-1:0] m);
        logic [DATA_W-1:0] r = '0;
        int start = 0;
        for (int b = 0; b < LANES; b++) begin
            if (b == LANES - 1 || m[b]) begin
                int w = LANE_W * (b - start + 1);
                logic [31:0] msk = (32'h1 << w) - 32'h1;
                logic [31:0] xs  = (32'(x) >> (LANE_W * start)) & msk;
                logic [31:0] ys  = (32'(y) >> (LANE_W * start)) & msk;
                logic [31:0] pick = (xs < ys) ? xs : ys;
                r = r | DATA_W'(pick << (LANE_W * start));
                start = b + 1;
            end
        end
        return r;
    endfunction

    // Compare the output to an expected value, reporting under a requirement tag
    task automatic check(input string tag, input logic [DATA_W-1:0] exp);
        checks++;
        if (min_out !== exp) begin
            fails++;
            $display("FAIL %s mask=%b x=%h y=%h actual=%h expected=%h",
                     tag, part_mask, op_x, op_y, min_out, exp);
        end
    endtask

    // Apply stimulus after a falling edge, sample mid-phase
    task automatic apply(input logic [CUTS-1:0] m, input logic [DATA_W-1:0] x,
                         input logic [DATA_W-1:0] y);
        @(negedge clk);
        part_mask = m; op_x = x; op_y = y;
        #5;
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(20 * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Main sequence
    initial begin
        part_mask = '0; op_x = '0; op_y = '0;
        // Idle state: zero operands give zero (R7)
        apply(3'b000, 16'h0000, 16'h0000);
        check("R7 idle zero", 16'h0000);

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][50:48], VEC[i][47:32], VEC[i][31:16]);
            check("R5 table", VEC[i][15:0]);
        end

        // Mask-only change with operands held, no clock edge between (R9)
        apply(3'b000, 16'h8001, 16'h7FFF);
        check("R9 before", 16'h7FFF);
        part_mask = 3'b010;
        #1;
        check("R9 after mask change", 16'h7F01);
        part_mask = 3'b111;
        #1;
        check("R9 lanes", 16'h7001);

        // Exhaustive mask sweep with edge and pseudo-random operands (R5, R2)
        for (int m = 0; m < (1 << CUTS); m++) begin
            apply(CUTS'(m), 16'h0000, 16'hFFFF);
            check("R5 zeros vs ones", ref_min(16'h0000, 16'hFFFF, CUTS'(m)));
            apply(CUTS'(m), 16'hFFFF, 16'h0000);
            check("R5 ones vs zeros", ref_min(16'hFFFF, 16'h0000, CUTS'(m)));
            apply(CUTS'(m), 16'h5A5A, 16'h5A5A);
            check("R7 equal", 16'h5A5A);
            for (int n = 0; n < 200; n++) begin
                logic [15:0] a, b;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                a = lfsr;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                // Bias some pairs to share upper lanes so lower lanes decide (R6)
                b = (n % 3 == 0) ? {a[15:8], lfsr[7:0]} : lfsr;
                apply(CUTS'(m), a, b);
                check("R2 R6 sweep", ref_min(a, b, CUTS'(m)));
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule